// File: doc/BRIEF.md
# External Pin Interrupt Detector

This block watches a small group of external interrupt pins and turns each one into a request line for an interrupt controller input. Each pin first passes through a synchroniser. Software then picks a trigger condition for the pin: off, rising edge, falling edge, either edge, high level or low level.

An edge condition sets a sticky capture bit. The bit stays set until software acknowledges it through a write-one-to-clear register. A level condition tracks the synchronised pin directly and stores nothing. A per-channel enable gates the stored or live condition onto the request output.

Software drives the block over a simple 32-bit register bus. The bus has a write strobe, a byte address and a combinational read path. Four registers sit on it: a packed trigger-code register, a capture view, a clear register and an enable register.

Top module: `extint_detect`

## Requirements
- R1: The trigger register sits at byte address 0x00. Channel i uses bits 4i+3..4i. It reads back as written, and bits above 4*NUM_CH read 0.
- R2: Code 1 (rising), code 2 (falling) and code 3 (both edges) set the channel's capture bit on the matching transition of the synchronised pin. The bit holds until it is cleared.
- R3: Code 5 (high) and code 6 (low) make the channel's condition follow the synchronised pin level. Nothing is latched, so the condition drops as soon as the pin leaves the active level.
- R4: Codes 0, 4 and 7 to 15 never set a capture bit and never raise a request.
- R5: The enable register sits at 0x0C, one bit per channel. A channel's request is high only while its enable bit is set. Clearing the enable bit removes the request but keeps any latched capture.
- R6: Reading 0x04 returns one bit per channel: the latched edge event, or the live level condition. Writes to 0x04 have no effect.
- R7: Writing 1 to a bit of the clear register at 0x08 drops that channel's capture bit. Writing 0 leaves it alone. The register reads as 0. An edge detected in the same cycle as the clear wins, and the bit stays set.
- R8: Any write to the trigger register clears all latched capture bits.
- R9: With the default two synchroniser stages, a level condition appears on the request 2 clock edges after the pin changes. An edge event appears 3 edges after the pin changes.
- R10: After reset, every register, capture bit and request reads 0.
- R11: The bring-up sequence works on an idle low pin: write code 6, write the channel's clear bit, then set its enable bit. The request is then high and stays high while the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte address; bits 1:0 must be 0 for a register hit |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| irq_o | output | NUM_CH | Per-channel interrupt requests |

## Verification
A pin change reaches a level request after the second rising clock edge and an edge request after the third. The bench changes pins on a falling edge, counts exactly that many rising edges and samples on the next falling edge. It also checks one edge earlier that the request is not yet there. Register writes take effect at the single rising edge inside the write strobe. Reads are sampled one nanosecond after the address settles, halfway between edges. The same-cycle clear-versus-edge case is lined up so that the clear strobe covers the third rising edge after the pin falls, which is the edge at which the event is latched.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int CODE_W = 4;
   localparam int MAX_CH = 6;

   localparam logic [CODE_W-1:0] TRIG_OFF  = 4'd0;
   localparam logic [CODE_W-1:0] TRIG_RISE = 4'd1;
   localparam logic [CODE_W-1:0] TRIG_FALL = 4'd2;
   localparam logic [CODE_W-1:0] TRIG_BOTH = 4'd3;
   localparam logic [CODE_W-1:0] TRIG_HIGH = 4'd5;
   localparam logic [CODE_W-1:0] TRIG_LOW  = 4'd6;

   typedef enum logic [1:0] {
      REG_CFG = 2'd0,
      REG_CAP = 2'd1,
      REG_CLR = 2'd2,
      REG_EN  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] st_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[STAGES-2:0], d_i};
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
   import extint_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pin_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              cfg_wr_i,
   input  logic              clr_i,
   input  logic              en_i,
   output logic              status_o,
   output logic              irq_o
);
   logic prev_q, lat_q;
   logic rise, fall, edge_hit, lvl, is_edge;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= pin_i;
   end

   always_comb begin
      rise     = pin_i & ~prev_q;
      fall     = ~pin_i & prev_q;
      edge_hit = 1'b0;
      lvl      = 1'b0;
      is_edge  = 1'b0;
      case (code_i)
         TRIG_RISE: begin is_edge = 1'b1; edge_hit = rise;        end
         TRIG_FALL: begin is_edge = 1'b1; edge_hit = fall;        end
         TRIG_BOTH: begin is_edge = 1'b1; edge_hit = rise | fall; end
         TRIG_HIGH: lvl = pin_i;
         TRIG_LOW:  lvl = ~pin_i;
         default:   ;
      endcase
   end

   // A trigger write wins; then a fresh edge beats an acknowledge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_q <= 1'b0;
      else if (cfg_wr_i) lat_q <= 1'b0;
      else if (edge_hit) lat_q <= 1'b1;
      else if (clr_i)    lat_q <= 1'b0;
   end

   assign status_o = lat_q | lvl;

   if (REG_OUT) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= en_i & status_o;
      end
      assign irq_o = irq_q;
   end else begin : g_comb_out
      assign irq_o = en_i & status_o;
   end

   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_q && !clr_i && !cfg_wr_i |=> lat_q);
   p_edge_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_hit && !cfg_wr_i |=> lat_q);
   p_noedge_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_edge |-> !lat_q);
   p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i && !$past(en_i) |-> !irq_o);
   p_clr_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !edge_hit && !cfg_wr_i |=> !lat_q);
   p_cfg_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr_i |=> !lat_q);
endmodule

// File: rtl/extint_regs.sv
module extint_regs
   import extint_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int DATA_W = 32,
   localparam int CFG_W = CODE_W * NUM_CH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [3:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NUM_CH-1:0] status_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CFG_W-1:0]  cfg_o,
   output logic              cfg_wr_o,
   output logic [NUM_CH-1:0] clr_o,
   output logic [NUM_CH-1:0] en_o
);
   logic             hit;
   reg_sel_e         sel;
   logic             en_wr;
   logic [CFG_W-1:0] cfg_q;
   logic [NUM_CH-1:0] en_q;

   assign hit      = (addr_i[1:0] == 2'b00);
   assign sel      = reg_sel_e'(addr_i[3:2]);
   assign cfg_wr_o = wr_i & hit & (sel == REG_CFG);
   assign en_wr    = wr_i & hit & (sel == REG_EN);
   assign clr_o    = (wr_i && hit && sel == REG_CLR) ? wdata_i[NUM_CH-1:0] : '0;

   if (CFG_W < DATA_W) begin : g_spare
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
         en_q  <= '0;
      end else begin
         if (cfg_wr_o) cfg_q <= wdata_i[CFG_W-1:0];
         if (en_wr)    en_q  <= wdata_i[NUM_CH-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         case (sel)
            REG_CFG: rdata_o[CFG_W-1:0]  = cfg_q;
            REG_CAP: rdata_o[NUM_CH-1:0] = status_i;
            REG_EN:  rdata_o[NUM_CH-1:0] = en_q;
            default: ;
         endcase
      end
   end

   assign cfg_o = cfg_q;
   assign en_o  = en_q;

   p_cfg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && hit && sel == REG_CFG |=> cfg_q == $past(wdata_i[CFG_W-1:0]));
   p_cfg_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && hit && sel == REG_CFG) |=> $stable(cfg_q));
   p_en_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && hit && sel == REG_EN |=> en_q == $past(wdata_i[NUM_CH-1:0]));
   p_en_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && hit && sel == REG_EN) |=> $stable(en_q));
endmodule

// File: rtl/extint_detect.sv
module extint_detect
   import extint_pkg::*;
#(
   parameter int NUM_CH      = 6,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              bus_wr_i,
   input  logic [3:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int CFG_W = CODE_W * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("extint_detect: NUM_CH out of range");
   end
   if (DATA_W < CFG_W) begin : g_bad_dw
      $error("extint_detect: DATA_W too narrow for packed trigger codes");
   end

   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] status;
   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] en;
   logic [CFG_W-1:0]  cfg;
   logic              cfg_wr;

   extint_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   extint_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .status_i(status),
      .rdata_o (bus_rdata_o),
      .cfg_o   (cfg),
      .cfg_wr_o(cfg_wr),
      .clr_o   (clr),
      .en_o    (en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      extint_chan #(.REG_OUT(REG_OUT)) u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .pin_i   (pin_s[c]),
         .code_i  (cfg[CODE_W*c +: CODE_W]),
         .cfg_wr_i(cfg_wr),
         .clr_i   (clr[c]),
         .en_i    (en[c]),
         .status_o(status[c]),
         .irq_o   (irq_o[c])
      );
   end
endmodule

// File: tb/extint_detect_bench.sv
module extint_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  pin = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [3:0] A_CFG = 4'h0, A_CAP = 4'h4, A_CLR = 4'h8, A_EN = 4'hC;

   always #4 clk = ~clk;

   extint_detect u_extint_detect (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .irq_o(irq)
   );

   // {channel[9:7], code[6:3], pin before[2], pin after[1], expected[0]}
   localparam logic [9:0] VEC [0:14] = '{
      {3'd0, 4'd1,  1'b0, 1'b1, 1'b1},
      {3'd0, 4'd1,  1'b1, 1'b0, 1'b0},
      {3'd1, 4'd2,  1'b1, 1'b0, 1'b1},
      {3'd1, 4'd2,  1'b0, 1'b1, 1'b0},
      {3'd2, 4'd3,  1'b0, 1'b1, 1'b1},
      {3'd2, 4'd3,  1'b1, 1'b0, 1'b1},
      {3'd2, 4'd3,  1'b0, 1'b0, 1'b0},
      {3'd3, 4'd5,  1'b0, 1'b1, 1'b1},
      {3'd3, 4'd5,  1'b1, 1'b0, 1'b0},
      {3'd4, 4'd6,  1'b1, 1'b0, 1'b1},
      {3'd4, 4'd6,  1'b0, 1'b1, 1'b0},
      {3'd5, 4'd0,  1'b0, 1'b1, 1'b0},
      {3'd5, 4'd4,  1'b0, 1'b1, 1'b0},
      {3'd0, 4'd7,  1'b1, 1'b0, 1'b0},
      {3'd1, 4'd15, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R10 reset state
      check("R10", "irq after reset", {26'd0, irq}, 32'd0);
      rd(A_CFG, d); check("R10", "trigger reg", d, 32'd0);
      rd(A_EN,  d); check("R10", "enable reg", d, 32'd0);
      rd(A_CAP, d); check("R10", "capture reg", d, 32'd0);

      // R1 packing and readback
      wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d);
      check("R1", "upper bits read zero", d, 32'h00FF_FFFF);
      wr(A_CFG, 32'h0065_3201); rd(A_CFG, d);
      check("R1", "mixed codes readback", d, 32'h0065_3201);

      // Table walk: R2 edges, R3 levels, R4 unused codes
      foreach (VEC[i]) begin
         automatic int         ch   = int'(VEC[i][9:7]);
         automatic logic [3:0] code = VEC[i][6:3];
         automatic logic [31:0] exp = {31'd0, VEC[i][0]} << ch;
         automatic string req = (code >= 1 && code <= 3) ? "R2" :
                                (code == 5 || code == 6) ? "R3" : "R4";
         wr(A_EN, 32'd0);
         @(negedge clk); pin = '0; pin[ch] = VEC[i][2];
         settle(4);
         wr(A_CFG, {28'd0, code} << (4*ch));
         wr(A_CLR, 32'h3F);
         wr(A_EN, 32'd1 << ch);
         pin[ch] = VEC[i][1];
         settle(4);
         check(req, $sformatf("vector %0d irq", i), {26'd0, irq}, exp);
         rd(A_CAP, d);
         check("R6", $sformatf("vector %0d capture", i), d, exp);
      end

      // R9 edge latency: request after the third edge, not the second
      wr(A_EN, 0); @(negedge clk); pin = '0; settle(4);
      wr(A_CFG, 32'h0000_5001); wr(A_CLR, 32'h3F); wr(A_EN, 32'h09);
      pin[0] = 1'b1;
      settle(2); check("R9", "edge not yet at 2", {26'd0, irq}, 32'd0);
      settle(1); check("R9", "edge at 3", {26'd0, irq}, 32'h01);
      // R9 level latency on channel 3
      pin[3] = 1'b1;
      settle(1); check("R9", "level not yet at 1", {26'd0, irq}, 32'h01);
      settle(1); check("R9", "level at 2", {26'd0, irq}, 32'h09);

      // R5 gating keeps the latch
      wr(A_EN, 32'h08);
      check("R5", "disabled edge channel", {26'd0, irq}, 32'h08);
      rd(A_CAP, d); check("R5", "capture kept while disabled", d, 32'h09);
      wr(A_EN, 32'h09);
      check("R5", "re-enabled edge channel", {26'd0, irq}, 32'h09);

      // R6 capture writes ignored
      wr(A_CAP, 32'h0); rd(A_CAP, d);
      check("R6", "write 0 to capture ignored", d, 32'h09);

      // R7 clear semantics
      wr(A_CLR, 32'h0); rd(A_CAP, d);
      check("R7", "clear with zeros", d, 32'h09);
      rd(A_CLR, d); check("R7", "clear reads zero", d, 32'd0);
      wr(A_CLR, 32'h1); rd(A_CAP, d);
      check("R7", "clear bit 0", d, 32'h08);
      check("R7", "irq after clear", {26'd0, irq}, 32'h08);

      // R8 trigger write drops latch (ch0 rising again, then rewrite)
      @(negedge clk); pin[0] = 1'b0; settle(4);
      pin[0] = 1'b1; settle(4);
      rd(A_CAP, d); check("R8", "latched before rewrite", d, 32'h09);
      wr(A_CFG, 32'h0000_5001); rd(A_CAP, d);
      check("R8", "capture after trigger write", d, 32'h08);

      // R7 same-cycle edge beats clear, channel 2 both edges
      wr(A_EN, 0); @(negedge clk); pin = '0; settle(4);
      wr(A_CFG, 32'h0000_0300); wr(A_CLR, 32'h3F); wr(A_EN, 32'h04);
      pin[2] = 1'b1; settle(4);
      check("R2", "both-edge rise latched", {26'd0, irq}, 32'h04);
      pin[2] = 1'b0;
      repeat (2) @(posedge clk);
      wr(A_CLR, 32'h04);
      rd(A_CAP, d); check("R7", "edge wins over clear", d, 32'h04);
      wr(A_CLR, 32'h04); rd(A_CAP, d);
      check("R7", "later clear works", d, 32'd0);
      wr(A_CAP, 32'h3F); rd(A_CAP, d);
      check("R6", "write 1s to capture ignored", d, 32'd0);

      // R11 bring-up on idle low pin, channel 4
      wr(A_EN, 0); @(negedge clk); pin = '0; settle(4);
      wr(A_CFG, 32'h0006_0000); wr(A_CLR, 32'h10); wr(A_EN, 32'h10);
      check("R11", "low-level request", {26'd0, irq}, 32'h10);
      settle(5);
      check("R11", "request stays while low", {26'd0, irq}, 32'h10);
      pin[4] = 1'b1; settle(2);
      check("R3", "low level released", {26'd0, irq}, 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule